// File: doc/BRIEF.md
# Burst-Splitting AXI Write Master

This block is a write master for a 32-bit AXI3-style bus. A client hands it one request: a start byte address, a total number of beats, a beat size code, a burst type, a transaction ID and two lead-in delays. A separate ready/valid data stream then supplies one data word and one optional byte strobe per beat. The block issues the transfer on the write-address and write-data channels. When the request is longer than sixteen beats it is cut into successive bursts of at most sixteen beats. The address of each following burst moves on by sixteen beats' worth of bytes.

The address sequencer and the data sequencer start together. Each waits its own programmed number of cycles and then runs at its own pace against the slave's ready signals. The response channel is always ready. Every burst is expected to return exactly one response. When the last response has arrived and both sequencers have finished, the block gives a one-cycle completion pulse. The pulse carries a flag that is set when any response was non-OKAY. No new request is taken while a transfer is in flight.

The control FSM has three states. T_IDLE moves to T_RUN on request acceptance. T_RUN moves to T_REPORT once all bursts are sent and answered. T_REPORT returns to T_IDLE after one cycle. The address sequencer has states AW_IDLE, AW_WAIT and AW_SEND. AW_IDLE goes to AW_WAIT on start with a non-zero delay, or straight to AW_SEND when the delay is zero. AW_WAIT goes to AW_SEND when the delay has run out. AW_SEND goes back to AW_IDLE when the last burst is accepted. The data sequencer has states W_IDLE, W_WAIT, W_FILL and W_SEND. W_IDLE goes to W_WAIT or W_FILL on start. W_WAIT goes to W_FILL when its delay has run out. W_FILL goes to W_SEND when a stream word is loaded. W_SEND stays in W_SEND when the next word is loaded on a handshake. It goes to W_FILL when no word is available, and to W_IDLE after the final beat.

Top module: `axi_wr_splitter`

## Requirements
- R1: A request of N beats (N ≥ 1) produces ceil(N/16) address phases. Every phase except the last carries AWLEN=15. The last carries AWLEN equal to the beats left minus one.
- R2: Burst k starts at start address + k·(16 << size), computed modulo 2^32.
- R3: Beat j (counting from 0 over the whole request) carries WLAST when j mod 16 = 15 or j = N−1. Beats reach the W channel in stream order, and exactly N beats are sent.
- R4: AWSIZE, AWBURST (0 fixed, 1 incrementing, 2 wrapping, 3 reserved) and AWID are the request's values on every burst. WID equals AWID. AWLOCK, AWCACHE, AWPROT and AWQOS are zero.
- R5: AWVALID first rises aw_delay clock edges after the accepting edge. WVALID first rises w_delay+1 edges after it when the data stream is ready at once.
- R6: Once AWVALID or WVALID is high without READY, it stays high in the next cycle with the address, length, data, strobe and last flag unchanged.
- R7: When dat_use_strb is 0 a beat's strobe is the low (1 << size) bits set, limited to 4 bits. When it is 1 the stream's strobe is passed unchanged.
- R8: BREADY is always 1. `done` is high for exactly one cycle, after every burst's response has arrived and both channels have finished.
- R9: `done_err` during the `done` pulse is 1 if and only if any response of the transfer had BRESP ≠ 0.
- R10: `req_ready` is 0 from acceptance until after the `done` pulse. A request presented in that time is ignored and produces no bus activity.
- R11: After reset AWVALID, WVALID and `done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (idle) |
| req_addr | input | 32 | Start byte address |
| req_beats | input | 16 | Total beats, at least 1 |
| req_size | input | 2 | Bytes per beat = 1 << size |
| req_burst | input | 2 | Burst type |
| req_id | input | 12 | Transaction ID |
| req_aw_delay | input | 4 | Address lead-in cycles |
| req_w_delay | input | 4 | Data lead-in cycles |
| dat_valid | input | 1 | Stream word present |
| dat_ready | output | 1 | Stream word taken |
| dat_data | input | 32 | Stream data |
| dat_strb | input | 4 | Stream byte strobe |
| dat_use_strb | input | 1 | Use stream strobe instead of default |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address ready |
| awaddr | output | 32 | Burst start address |
| awlen | output | 4 | Beats in burst minus one |
| awsize | output | 2 | Beat size code |
| awburst | output | 2 | Burst type |
| awid | output | 12 | Transaction ID |
| awlock | output | 2 | Tied zero |
| awcache | output | 4 | Tied zero |
| awprot | output | 3 | Tied zero |
| awqos | output | 4 | Tied zero |
| wvalid | output | 1 | Data valid |
| wready | input | 1 | Data ready |
| wdata | output | 32 | Beat data |
| wstrb | output | 4 | Beat strobe |
| wlast | output | 1 | Last beat of burst |
| wid | output | 12 | Data ID |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |
| bresp | input | 2 | Response code |
| done | output | 1 | Transfer complete pulse |
| done_err | output | 1 | Error seen, valid with done |

## Verification
The split is tried with lengths of 1, 15, 16, 17, 33, 40 and 48 beats. These separate a single short burst, an exact full burst, a full burst followed by a one-beat remainder, and several full bursts followed by a partial one. Sizes 0 to 3 separate the address step per burst, and one case checks the wrap of the 32-bit address. Runs with and without ready stalls, with different lead-in delays, and with an error on the first, second or no response separate the hold rule, the delay timing and the error latch. A directed case keeps a second request asserted during a transfer to show that it is ignored.

// File: rtl/axi_wsplit_pkg.sv
package axi_wsplit_pkg;

    localparam int BURST_MAX = 16;
    localparam int LEN_W     = 4;
    localparam int SIZE_W    = 2;
    localparam int RESP_W    = 2;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RUN,
        T_REPORT
    } ctl_state_e;

    typedef enum logic [1:0] {
        AW_IDLE,
        AW_WAIT,
        AW_SEND
    } aw_state_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_WAIT,
        W_FILL,
        W_SEND
    } w_state_e;

endpackage

// File: rtl/axi_wsplit_aw.sv
module axi_wsplit_aw
    import axi_wsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int ID_W   = 12,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [CNT_W-1:0]  st_beats,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [1:0]        st_burst,
    input  logic [ID_W-1:0]   st_id,
    input  logic [DLY_W-1:0]  st_delay,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    output logic [SIZE_W-1:0] awsize,
    output logic [1:0]        awburst,
    output logic [ID_W-1:0]   awid,
    output logic              busy
);

    aw_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [SIZE_W-1:0] size_q;
    logic [1:0]        burst_q;
    logic [ID_W-1:0]   id_q;
    logic [DLY_W-1:0]  dly_q;
    logic              more_full;
    logic              fire;
    logic [ADDR_W-1:0] step;

    assign more_full = rem_q > CNT_W'(BURST_MAX);
    assign fire      = awvalid && awready;
    assign step      = ADDR_W'(BURST_MAX) << size_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AW_IDLE: if (start) state_d = (st_delay == '0) ? AW_SEND : AW_WAIT;
            AW_WAIT: if (dly_q == DLY_W'(1)) state_d = AW_SEND;
            AW_SEND: if (fire && !more_full) state_d = AW_IDLE;
            default: state_d = AW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AW_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            size_q  <= '0;
            burst_q <= '0;
            id_q    <= '0;
            dly_q   <= '0;
        end else begin
            if (state_q == AW_IDLE && start) begin
                addr_q  <= st_addr;
                rem_q   <= st_beats;
                size_q  <= st_size;
                burst_q <= st_burst;
                id_q    <= st_id;
                dly_q   <= st_delay;
            end else if (state_q == AW_WAIT) begin
                dly_q <= dly_q - DLY_W'(1);
            end else if (state_q == AW_SEND && fire && more_full) begin
                addr_q <= addr_q + step;
                rem_q  <= rem_q - CNT_W'(BURST_MAX);
            end
        end
    end

    always_comb begin
        awvalid = (state_q == AW_SEND);
        busy    = (state_q != AW_IDLE);
        awaddr  = addr_q;
        awlen   = more_full ? LEN_W'(BURST_MAX - 1) : LEN_W'(rem_q - CNT_W'(1));
        awsize  = size_q;
        awburst = burst_q;
        awid    = id_q;
    end

    assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    assert_aw_short_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && awready && (awlen != LEN_W'(BURST_MAX - 1)) |=> !awvalid);

endmodule

// File: rtl/axi_wsplit_w.sv
module axi_wsplit_w
    import axi_wsplit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ID_W   = 12,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  st_beats,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [ID_W-1:0]   st_id,
    input  logic [DLY_W-1:0]  st_delay,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_data,
    input  logic [DATA_W/8-1:0] dat_strb,
    input  logic              dat_use_strb,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic              wlast,
    output logic [ID_W-1:0]   wid,
    output logic              busy
);

    localparam int STRB_W = DATA_W / 8;

    w_state_e           state_q, state_d;
    logic [CNT_W-1:0]   idx_q;
    logic [CNT_W-1:0]   total_q;
    logic [SIZE_W-1:0]  size_q;
    logic [ID_W-1:0]    id_q;
    logic [DLY_W-1:0]   dly_q;
    logic [DATA_W-1:0]  data_q;
    logic [STRB_W-1:0]  strb_q;
    logic [STRB_W-1:0]  dflt_strb;
    logic               final_beat;
    logic               fire;
    logic               load;

    assign final_beat = (idx_q == total_q - CNT_W'(1));
    assign fire       = wvalid && wready;
    assign load       = dat_valid && dat_ready;

    always_comb begin
        for (int i = 0; i < STRB_W; i++) begin
            dflt_strb[i] = (i < (1 << size_q));
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (start) state_d = (st_delay == '0) ? W_FILL : W_WAIT;
            W_WAIT: if (dly_q == DLY_W'(1)) state_d = W_FILL;
            W_FILL: if (dat_valid) state_d = W_SEND;
            W_SEND: begin
                if (fire) begin
                    if (final_beat)     state_d = W_IDLE;
                    else if (dat_valid) state_d = W_SEND;
                    else                state_d = W_FILL;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            total_q <= '0;
            size_q  <= '0;
            id_q    <= '0;
            dly_q   <= '0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            if (state_q == W_IDLE && start) begin
                idx_q   <= '0;
                total_q <= st_beats;
                size_q  <= st_size;
                id_q    <= st_id;
                dly_q   <= st_delay;
            end
            if (state_q == W_WAIT) dly_q <= dly_q - DLY_W'(1);
            if (fire) idx_q <= idx_q + CNT_W'(1);
            if (load) begin
                data_q <= dat_data;
                strb_q <= dat_use_strb ? dat_strb : dflt_strb;
            end
        end
    end

    always_comb begin
        wvalid    = (state_q == W_SEND);
        dat_ready = (state_q == W_FILL) || ((state_q == W_SEND) && wready && !final_beat);
        busy      = (state_q != W_IDLE);
        wdata     = data_q;
        wstrb     = strb_q;
        wlast     = (&idx_q[LEN_W-1:0]) || final_beat;
        wid       = id_q;
    end

    assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast));

    assert_w_nonlast_keeps_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && !wlast |=> busy);

endmodule

// File: rtl/axi_wsplit_b.sv
module axi_wsplit_b
    import axi_wsplit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  st_beats,
    input  logic              bvalid,
    input  logic [RESP_W-1:0] bresp,
    output logic              all_seen,
    output logic              err
);

    localparam int CW1 = CNT_W + 1;

    logic [CW1-1:0] exp_q;
    logic [CW1-1:0] got_q;
    logic           err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            got_q <= '0;
            err_q <= 1'b0;
        end else if (start) begin
            exp_q <= ({1'b0, st_beats} + CW1'(BURST_MAX - 1)) >> LEN_W;
            got_q <= '0;
            err_q <= 1'b0;
        end else if (bvalid) begin
            got_q <= got_q + CW1'(1);
            if (bresp != '0) err_q <= 1'b1;
        end
    end

    assign all_seen = (got_q == exp_q);
    assign err      = err_q;

    assert_b_no_excess_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !start |-> got_q < exp_q);

endmodule

// File: rtl/axi_wr_splitter.sv
module axi_wr_splitter
    import axi_wsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 12,
    parameter int CNT_W  = 16,
    parameter int DLY_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [CNT_W-1:0]    req_beats,
    input  logic [1:0]          req_size,
    input  logic [1:0]          req_burst,
    input  logic [ID_W-1:0]     req_id,
    input  logic [DLY_W-1:0]    req_aw_delay,
    input  logic [DLY_W-1:0]    req_w_delay,
    input  logic                dat_valid,
    output logic                dat_ready,
    input  logic [DATA_W-1:0]   dat_data,
    input  logic [DATA_W/8-1:0] dat_strb,
    input  logic                dat_use_strb,
    output logic                awvalid,
    input  logic                awready,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [3:0]          awlen,
    output logic [1:0]          awsize,
    output logic [1:0]          awburst,
    output logic [ID_W-1:0]     awid,
    output logic [1:0]          awlock,
    output logic [3:0]          awcache,
    output logic [2:0]          awprot,
    output logic [3:0]          awqos,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    output logic [ID_W-1:0]     wid,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp,
    output logic                done,
    output logic                done_err
);

    ctl_state_e state_q, state_d;
    logic       start;
    logic       aw_busy;
    logic       w_busy;
    logic       all_seen;
    logic       err;

    assign start = req_valid && (state_q == T_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:   if (start) state_d = T_RUN;
            T_RUN:    if (!aw_busy && !w_busy && all_seen) state_d = T_REPORT;
            T_REPORT: state_d = T_IDLE;
            default:  state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == T_IDLE);
        done      = (state_q == T_REPORT);
        done_err  = err;
        bready    = 1'b1;
        awlock    = '0;
        awcache   = '0;
        awprot    = '0;
        awqos     = '0;
    end

    axi_wsplit_aw #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .ID_W   (ID_W),
        .DLY_W  (DLY_W)
    ) u_aw (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st_addr  (req_addr),
        .st_beats (req_beats),
        .st_size  (req_size),
        .st_burst (req_burst),
        .st_id    (req_id),
        .st_delay (req_aw_delay),
        .awvalid  (awvalid),
        .awready  (awready),
        .awaddr   (awaddr),
        .awlen    (awlen),
        .awsize   (awsize),
        .awburst  (awburst),
        .awid     (awid),
        .busy     (aw_busy)
    );

    axi_wsplit_w #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ID_W   (ID_W),
        .DLY_W  (DLY_W)
    ) u_w (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .st_beats     (req_beats),
        .st_size      (req_size),
        .st_id        (req_id),
        .st_delay     (req_w_delay),
        .dat_valid    (dat_valid),
        .dat_ready    (dat_ready),
        .dat_data     (dat_data),
        .dat_strb     (dat_strb),
        .dat_use_strb (dat_use_strb),
        .wvalid       (wvalid),
        .wready       (wready),
        .wdata        (wdata),
        .wstrb        (wstrb),
        .wlast        (wlast),
        .wid          (wid),
        .busy         (w_busy)
    );

    axi_wsplit_b #(
        .CNT_W (CNT_W)
    ) u_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .st_beats (req_beats),
        .bvalid   (bvalid && bready),
        .bresp    (bresp),
        .all_seen (all_seen),
        .err      (err)
    );

    assert_done_after_channels_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !aw_busy && !w_busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_means_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !aw_busy && !w_busy);

    assert_wid_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && awvalid |-> wid == awid);

endmodule

// File: tb/axi_wr_splitter_bench.sv
`timescale 1ns/1ps
module axi_wr_splitter_bench;

    typedef struct packed {
        logic [15:0] beats;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [1:0]  burst;
        logic [3:0]  awd;
        logic [3:0]  wd;
        logic        stall;
        logic        use_strb;
        logic [7:0]  errb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd1,  32'h0000_1000, 2'd2, 2'd1, 4'd0, 4'd0, 1'b0, 1'b0, 8'hFF},
        '{16'd16, 32'h0000_2000, 2'd2, 2'd1, 4'd0, 4'd0, 1'b0, 1'b1, 8'hFF},
        '{16'd17, 32'h0000_3004, 2'd2, 2'd1, 4'd2, 4'd0, 1'b1, 1'b0, 8'hFF},
        '{16'd40, 32'h0000_4000, 2'd1, 2'd0, 4'd0, 4'd3, 1'b0, 1'b0, 8'd1},
        '{16'd33, 32'h0000_5000, 2'd0, 2'd2, 4'd5, 4'd1, 1'b1, 1'b0, 8'd0},
        '{16'd48, 32'hFFFF_FF00, 2'd3, 2'd1, 4'd1, 4'd1, 1'b1, 1'b0, 8'hFF},
        '{16'd15, 32'h0000_0100, 2'd2, 2'd3, 4'd0, 4'd7, 1'b0, 1'b1, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_beats = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic [11:0] req_id = '0;
    logic [3:0]  req_aw_delay = '0;
    logic [3:0]  req_w_delay = '0;
    logic        dat_valid;
    logic        dat_ready;
    logic [31:0] dat_data;
    logic [3:0]  dat_strb;
    logic        dat_use_strb;
    logic        awvalid, awready;
    logic [31:0] awaddr;
    logic [3:0]  awlen;
    logic [1:0]  awsize, awburst;
    logic [11:0] awid;
    logic [1:0]  awlock;
    logic [3:0]  awcache;
    logic [2:0]  awprot;
    logic [3:0]  awqos;
    logic        wvalid, wready;
    logic [31:0] wdata;
    logic [3:0]  wstrb;
    logic        wlast;
    logic [11:0] wid;
    logic        bvalid = 1'b0;
    logic        bready;
    logic [1:0]  bresp = '0;
    logic        done, done_err;

    int          checks = 0;
    int          bad = 0;
    logic [31:0] cyc = '0;
    logic        clr = 1'b0;
    logic [15:0] src_idx = '0;
    int          pend = 0;
    int          b_idx = 0;

    logic [15:0] cur_beats = '0;
    logic [31:0] cur_addr = '0;
    logic [1:0]  cur_size = '0;
    logic [1:0]  cur_burst = '0;
    logic [11:0] cur_id = '0;
    logic        cur_stall = 1'b0;
    logic        cur_use_strb = 1'b0;
    logic [7:0]  cur_errb = 8'hFF;
    logic [31:0] cur_seed = '0;
    int          aw_n = 0;
    int          w_n = 0;
    longint      first_aw = -1;
    longint      first_w = -1;
    logic        prev_aw_stall = 1'b0;
    logic        prev_w_stall = 1'b0;
    logic [31:0] prev_awaddr = '0;
    logic [3:0]  prev_awlen = '0;
    logic [31:0] prev_wdata = '0;
    logic        prev_wlast = 1'b0;

    always #10 clk = ~clk;

    axi_wr_splitter u_axi_wr_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_beats(req_beats), .req_size(req_size), .req_burst(req_burst),
        .req_id(req_id), .req_aw_delay(req_aw_delay), .req_w_delay(req_w_delay),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
        .dat_strb(dat_strb), .dat_use_strb(dat_use_strb),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst), .awid(awid), .awlock(awlock),
        .awcache(awcache), .awprot(awprot), .awqos(awqos),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .wlast(wlast), .wid(wid),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .done(done), .done_err(done_err)
    );

    assign awready      = !cur_stall || (cyc % 3 != 0);
    assign wready       = !cur_stall || (cyc % 4 != 1);
    assign dat_valid    = 1'b1;
    assign dat_data     = cur_seed + 32'(src_idx);
    assign dat_strb     = src_idx[3:0] ^ 4'h5;
    assign dat_use_strb = cur_use_strb;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (clr) src_idx <= '0;
        else if (dat_valid && dat_ready) src_idx <= src_idx + 16'd1;
    end

    // bench slave response channel: one response per last beat
    always @(posedge clk) begin
        int inc, dec, np;
        if (!rst_n || clr) begin
            pend   <= 0;
            b_idx  <= 0;
            bvalid <= 1'b0;
            bresp  <= 2'b00;
        end else begin
            inc = (wvalid && wready && wlast) ? 1 : 0;
            dec = bvalid ? 1 : 0;
            np  = pend + inc - dec;
            pend   <= np;
            b_idx  <= b_idx + dec;
            bvalid <= (np > 0);
            bresp  <= ((b_idx + dec) == int'(cur_errb)) ? 2'b10 : 2'b00;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (awvalid && first_aw < 0) first_aw = longint'(cyc);
            if (wvalid && first_w < 0)   first_w  = longint'(cyc);
            if (prev_aw_stall)
                check(awvalid && awaddr == prev_awaddr && awlen == prev_awlen,
                      "R6", "aw hold", {awvalid, awaddr}, {1'b1, prev_awaddr});
            if (prev_w_stall)
                check(wvalid && wdata == prev_wdata && wlast == prev_wlast,
                      "R6", "w hold", {wvalid, wdata}, {1'b1, prev_wdata});
            prev_aw_stall = awvalid && !awready;
            prev_w_stall  = wvalid && !wready;
            prev_awaddr   = awaddr;
            prev_awlen    = awlen;
            prev_wdata    = wdata;
            prev_wlast    = wlast;
            if (awvalid && awready) begin
                int rem;
                logic [3:0]  elen;
                logic [31:0] eaddr;
                rem   = int'(cur_beats) - 16 * aw_n;
                elen  = (rem > 16) ? 4'd15 : 4'(rem - 1);
                eaddr = cur_addr + 32'(aw_n) * (32'd16 << cur_size);
                check(awlen == elen, "R1", "awlen", awlen, elen);
                check(awaddr == eaddr, "R2", "awaddr", awaddr, eaddr);
                check(awsize == cur_size && awburst == cur_burst && awid == cur_id,
                      "R4", "size/burst/id", {awsize, awburst, awid}, {cur_size, cur_burst, cur_id});
                check(awlock == 0 && awcache == 0 && awprot == 0 && awqos == 0,
                      "R4", "tied fields", {awlock, awcache, awprot, awqos}, 0);
                aw_n++;
            end
            if (wvalid && wready) begin
                logic        elast;
                logic [3:0]  estrb;
                logic [31:0] edata;
                elast = (w_n % 16 == 15) || (w_n == int'(cur_beats) - 1);
                edata = cur_seed + 32'(w_n);
                if (cur_use_strb) estrb = 4'(w_n) ^ 4'h5;
                else for (int i = 0; i < 4; i++) estrb[i] = (i < (1 << cur_size));
                check(wdata == edata, "R3", "wdata order", wdata, edata);
                check(wlast == elast, "R3", "wlast", wlast, elast);
                check(wstrb == estrb, "R7", "wstrb", wstrb, estrb);
                check(wid == cur_id, "R4", "wid", wid, cur_id);
                w_n++;
            end
        end
    end

    task automatic run_req(input int v, input bit hold_busy);
        vec_t        t;
        longint      acc;
        int          nb, n;
        logic        eerr;
        t = VECS[v];
        @(negedge clk);
        cur_beats    = t.beats;
        cur_addr     = t.addr;
        cur_size     = t.size;
        cur_burst    = t.burst;
        cur_id       = 12'(12'h100 + v * 37);
        cur_stall    = t.stall;
        cur_use_strb = t.use_strb;
        cur_errb     = t.errb;
        cur_seed     = 32'hA500_0000 + (32'(v) << 16);
        aw_n = 0; w_n = 0; first_aw = -1; first_w = -1;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        req_addr     = t.addr;
        req_beats    = t.beats;
        req_size     = t.size;
        req_burst    = t.burst;
        req_id       = cur_id;
        req_aw_delay = t.awd;
        req_w_delay  = t.wd;
        req_valid    = 1'b1;
        acc = longint'(cyc);
        check(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        @(negedge clk);
        if (hold_busy) begin
            req_addr = 32'hDEAD_0000;
            for (int k = 0; k < 6; k++) begin
                check(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        nb   = (int'(t.beats) + 15) / 16;
        eerr = (t.errb != 8'hFF) && (int'(t.errb) < nb);
        check(done == 1'b1, "R8", "done reached", done, 1);
        check(done_err == eerr, "R9", "done_err", done_err, eerr);
        check(aw_n == nb, "R1", "burst count", aw_n, nb);
        check(w_n == int'(t.beats), "R3", "beat count", w_n, t.beats);
        check(first_aw == acc + 1 + longint'(t.awd), "R5", "aw lead-in", first_aw, acc + 1 + t.awd);
        check(first_w == acc + 2 + longint'(t.wd), "R5", "w lead-in", first_w, acc + 2 + t.wd);
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", done, 0);
        check(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(awvalid == 1'b0 && wvalid == 1'b0 && done == 1'b0, "R11", "outputs in reset",
              {awvalid, wvalid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
        check(bready == 1'b1, "R8", "bready high", bready, 1);
        check(awvalid == 1'b0 && wvalid == 1'b0, "R11", "quiet after reset", {awvalid, wvalid}, 0);

        for (int v = 0; v < NV; v++) run_req(v, 1'b0);

        // R10: second request held during a transfer must be ignored
        run_req(2, 1'b1);
        repeat (5) @(negedge clk);
        check(awvalid == 1'b0 && wvalid == 1'b0, "R10", "no activity after ignored request",
              {awvalid, wvalid}, 0);
        check(bready == 1'b1, "R8", "bready still high", bready, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule